// File: doc/BRIEF.md
# Two-Bank DRAM Command Timing Tracker

This block sits between a memory controller and a synchronous DRAM with two banks. The controller raises a request, one command code per cycle, together with a bank bit and an auto-precharge bit. In the same cycle the block answers with exactly one of three replies. Grant means the command is issued. Stall means the command is legal but a timing limit is still open, so the controller keeps the request until it is granted. Illegal means the request breaks the bank state and is dropped.

A granted command is driven onto the chip-select, row-strobe, column-strobe and write-enable pins, the A10 pin and the bank pin one clock later. A cycle with no grant drives a NOP. Every timing limit is a parameter counted in clock cycles. Each bank keeps its own open/idle flag and down-counters. A few shared counters cover the cross-bank rules: mode-set and refresh lockout, read after write, read-burst ownership and the auto-precharge in flight.

Top module: `dram_cmd_gate`

## Requirements
- R1: Request codes on `req_cmd` are NOP=0, ACT=1, RD=2, WR=3, PRE=4, REF=5, MRS=6, BST=7. One cycle after a grant the pins {cs_n,ras_n,cas_n,we_n} show MRS 0000, REF 0001, ACT 0011, RD 0101, WR 0100, PRE 0010, BST 0110, NOP 0111. After reset, and after any cycle without a grant, they show 0111.
- R2: For RD and WR, `dram_a10` equals the auto-precharge bit. For PRE, `dram_a10` equals `req_ap`, and `req_ap`=1 means both banks are precharged. `dram_ba` carries the bank bit (0 selects bank A, 1 selects bank B) for ACT, RD, WR and single-bank PRE, and is 0 otherwise.
- R3: The block flags these requests as illegal and does not issue them: ACT to an open bank that is not closing under auto-precharge, RD or WR to an idle bank, and REF or MRS while any bank is open.
- R4: RD or WR to a bank is granted no earlier than T_RCD cycles after that bank's ACT.
- R5: PRE to an open bank waits T_RAS cycles after its ACT. ACT waits T_RP cycles after that bank's precharge and T_RC cycles after its previous ACT.
- R6: Two ACT commands are at least T_RRD cycles apart, whichever banks they target.
- R7: After a WR at cycle c, PRE to that bank waits until c+BL+T_WR-1 and any RD waits until c+BL+T_CDL-1. A WR is not held by this rule.
- R8: After MRS every request stalls for T_MRD cycles. After REF every request stalls for T_RC cycles. REF and MRS also wait until the precharge time of both banks has elapsed.
- R9: After a RD with auto-precharge at cycle c, the bank closes itself at c+BL. After a WR with auto-precharge, it closes at c+BL+T_WR-1. Until the cycle after it closes, no RD or WR is granted, and ACT or PRE to that bank stalls. ACT to it is granted T_RP cycles after it closes.
- R10: While a read burst is running (cycles c to c+BL-1 after a RD at c), a single-bank PRE to the other bank stalls. PRE to the same bank, or to both banks, is not held. BST ends the read burst.
- R11: When `req_valid` is high, exactly one of grant, stall and illegal is high. When it is low, none of them is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | A command request is present |
| req_cmd | input | 3 | Requested command code (R1) |
| req_bank | input | 1 | Target bank, 0 = A, 1 = B |
| req_ap | input | 1 | Auto-precharge for RD/WR, both banks for PRE |
| req_grant | output | 1 | Request issued this cycle |
| req_stall | output | 1 | Request legal, timing not yet met |
| req_illegal | output | 1 | Request breaks bank state, dropped |
| dram_cs_n | output | 1 | Chip select, active low |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_a10 | output | 1 | A10 pin: auto-precharge / precharge-all |
| dram_ba | output | 1 | Bank select pin |

## Verification
The assertions assume that a stalled request is held unchanged until it is granted, and that every timing parameter is at least one. The cross-cycle properties for mode-set lockout and activate spacing also assume that those limits are two or more. The bench follows these rules: it keeps each request up until the grant, shows an illegal request for a single cycle only, and uses the default configuration. In that configuration T_RC differs from T_RAS+T_RP, and the write-recovery window differs from the read-after-write window. The bench measures the distance in cycles between grants for every timing rule and checks it against the largest of the limits that apply.

// File: rtl/dram_gate_pkg.sv
package dram_gate_pkg;

    typedef enum logic [2:0] {
        CMD_NOP = 3'd0,
        CMD_ACT = 3'd1,
        CMD_RD  = 3'd2,
        CMD_WR  = 3'd3,
        CMD_PRE = 3'd4,
        CMD_REF = 3'd5,
        CMD_MRS = 3'd6,
        CMD_BST = 3'd7
    } req_cmd_e;

    typedef struct packed {
        logic cs_n;
        logic ras_n;
        logic cas_n;
        logic we_n;
    } pin_cmd_t;

    localparam pin_cmd_t PINS_NOP = 4'b0111;

    function automatic pin_cmd_t encode_cmd(req_cmd_e c);
        pin_cmd_t p;
        case (c)
            CMD_MRS: p = 4'b0000;
            CMD_REF: p = 4'b0001;
            CMD_ACT: p = 4'b0011;
            CMD_RD:  p = 4'b0101;
            CMD_WR:  p = 4'b0100;
            CMD_PRE: p = 4'b0010;
            CMD_BST: p = 4'b0110;
            default: p = PINS_NOP;
        endcase
        return p;
    endfunction

    function automatic int imax(int a, int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dram_bank_timer.sv
module dram_bank_timer #(
    parameter int T_RCD  = 3,
    parameter int T_RP   = 3,
    parameter int T_RAS  = 6,
    parameter int T_RC   = 10,
    parameter int T_WREC = 5,
    parameter int CW     = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic act_i,
    input  logic wr_i,
    input  logic close_i,
    output logic open_o,
    output logic act_ok_o,
    output logic col_ok_o,
    output logic pre_ok_o,
    output logic rp_done_o
);

    typedef struct packed {
        logic          open;
        logic [CW-1:0] rcd;
        logic [CW-1:0] rp;
        logic [CW-1:0] ras;
        logic [CW-1:0] rc;
        logic [CW-1:0] wrec;
    } bank_st_t;

    bank_st_t st_q, st_d;

    function automatic logic [CW-1:0] step_down(logic [CW-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

    always_comb begin
        st_d      = st_q;
        st_d.rcd  = step_down(st_q.rcd);
        st_d.rp   = step_down(st_q.rp);
        st_d.ras  = step_down(st_q.ras);
        st_d.rc   = step_down(st_q.rc);
        st_d.wrec = step_down(st_q.wrec);
        if (act_i) begin
            st_d.open = 1'b1;
            st_d.rcd  = CW'(T_RCD - 1);
            st_d.ras  = CW'(T_RAS - 1);
            st_d.rc   = CW'(T_RC - 1);
        end
        if (wr_i) begin
            st_d.wrec = CW'(T_WREC - 1);
        end
        if (close_i) begin
            st_d.open = 1'b0;
            st_d.rp   = CW'(T_RP - 1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign open_o    = st_q.open;
    assign act_ok_o  = !st_q.open && (st_q.rp == '0) && (st_q.rc == '0);
    assign col_ok_o  = st_q.open && (st_q.rcd == '0);
    assign pre_ok_o  = (st_q.ras == '0) && (st_q.wrec == '0);
    assign rp_done_o = (st_q.rp == '0);

    p_act_needs_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> !st_q.open);

    p_write_after_rcd_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |-> (st_q.open && st_q.rcd == '0));

    p_act_after_rp_rc_r5: assert property (@(posedge clk) disable iff (!rst_n)
        act_i |-> (st_q.rp == '0 && st_q.rc == '0));

    p_close_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
        close_i |=> !open_o);

endmodule

// File: rtl/dram_pin_drive.sv
module dram_pin_drive
    import dram_gate_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     fire_i,
    input  req_cmd_e cmd_i,
    input  logic     ap_i,
    input  logic     bank_i,
    output pin_cmd_t pins_o,
    output logic     a10_o,
    output logic     ba_o
);

    typedef struct packed {
        pin_cmd_t pins;
        logic     a10;
        logic     ba;
    } pin_st_t;

    pin_st_t out_q, out_d;

    always_comb begin
        out_d.pins = PINS_NOP;
        out_d.a10  = 1'b0;
        out_d.ba   = 1'b0;
        if (fire_i) begin
            out_d.pins = encode_cmd(cmd_i);
            case (cmd_i)
                CMD_ACT: out_d.ba = bank_i;
                CMD_RD, CMD_WR: begin
                    out_d.a10 = ap_i;
                    out_d.ba  = bank_i;
                end
                CMD_PRE: begin
                    out_d.a10 = ap_i;
                    out_d.ba  = ap_i ? 1'b0 : bank_i;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) out_q <= '{pins: PINS_NOP, a10: 1'b0, ba: 1'b0};
        else        out_q <= out_d;
    end

    assign pins_o = out_q.pins;
    assign a10_o  = out_q.a10;
    assign ba_o   = out_q.ba;

    p_idle_drives_nop_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !fire_i |=> (pins_o == PINS_NOP));

    p_prech_all_a10_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (fire_i && cmd_i == CMD_PRE && ap_i) |=> (a10_o && !ba_o));

endmodule

// File: rtl/dram_cmd_gate.sv
module dram_cmd_gate
    import dram_gate_pkg::*;
#(
    parameter int T_RCD     = 3,
    parameter int T_RP      = 3,
    parameter int T_RAS     = 6,
    parameter int T_RC      = 10,
    parameter int T_RRD     = 2,
    parameter int T_WR      = 2,
    parameter int T_CDL     = 1,
    parameter int T_MRD     = 2,
    parameter int BURST_LEN = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_valid,
    input  logic [2:0] req_cmd,
    input  logic       req_bank,
    input  logic       req_ap,
    output logic       req_grant,
    output logic       req_stall,
    output logic       req_illegal,
    output logic       dram_cs_n,
    output logic       dram_ras_n,
    output logic       dram_cas_n,
    output logic       dram_we_n,
    output logic       dram_a10,
    output logic       dram_ba
);

    localparam int NB       = 2;
    localparam int T_WREC   = BURST_LEN + T_WR - 1;
    localparam int T_RAW    = BURST_LEN + T_CDL - 1;
    localparam int T_AP_RD  = BURST_LEN;
    localparam int T_AP_WR  = T_WREC;
    localparam int MAXT     = imax(imax(imax(T_RC, T_RAS), imax(T_WREC, T_RAW)),
                                   imax(imax(T_MRD, T_RRD), imax(T_RCD, T_RP)));
    localparam int CW       = $clog2(MAXT + 1);

    typedef struct packed {
        logic [CW-1:0] rrd;
        logic [CW-1:0] busy;
        logic [CW-1:0] raw;
        logic [CW-1:0] rd;
        logic [CW-1:0] ap;
        logic          rd_bank;
        logic          ap_pend;
        logic          ap_bank;
    } gbl_t;

    gbl_t g_q, g_d;

    logic [NB-1:0] b_open, b_act_ok, b_col_ok, b_pre_ok, b_rp_done;
    logic [NB-1:0] act_v, wr_v, close_v;
    req_cmd_e      cmd;
    logic          illegal_c, ready_c, grant_c, ap_fire;
    pin_cmd_t      pins;

    function automatic logic [CW-1:0] step_down(logic [CW-1:0] v);
        return (v != '0) ? v - 1'b1 : v;
    endfunction

    for (genvar i = 0; i < NB; i++) begin : g_bank
        dram_bank_timer #(
            .T_RCD (T_RCD),
            .T_RP  (T_RP),
            .T_RAS (T_RAS),
            .T_RC  (T_RC),
            .T_WREC(T_WREC),
            .CW    (CW)
        ) u_bank (
            .clk      (clk),
            .rst_n    (rst_n),
            .act_i    (act_v[i]),
            .wr_i     (wr_v[i]),
            .close_i  (close_v[i]),
            .open_o   (b_open[i]),
            .act_ok_o (b_act_ok[i]),
            .col_ok_o (b_col_ok[i]),
            .pre_ok_o (b_pre_ok[i]),
            .rp_done_o(b_rp_done[i])
        );
    end

    always_comb begin
        cmd       = req_cmd_e'(req_cmd);
        ap_fire   = g_q.ap_pend && (g_q.ap == '0);
        illegal_c = 1'b0;
        ready_c   = 1'b0;

        case (cmd)
            CMD_ACT: begin
                illegal_c = b_open[req_bank] && !(g_q.ap_pend && g_q.ap_bank == req_bank);
                ready_c   = b_act_ok[req_bank] && (g_q.rrd == '0);
            end
            CMD_RD: begin
                illegal_c = !b_open[req_bank];
                ready_c   = b_col_ok[req_bank] && !g_q.ap_pend && (g_q.raw == '0);
            end
            CMD_WR: begin
                illegal_c = !b_open[req_bank];
                ready_c   = b_col_ok[req_bank] && !g_q.ap_pend;
            end
            CMD_PRE: begin
                if (req_ap) begin
                    ready_c = !g_q.ap_pend && (&(~b_open | b_pre_ok));
                end else begin
                    ready_c = !b_open[req_bank] ||
                              (b_pre_ok[req_bank] &&
                               !(g_q.ap_pend && g_q.ap_bank == req_bank) &&
                               !(g_q.rd != '0 && g_q.rd_bank != req_bank));
                end
            end
            CMD_REF, CMD_MRS: begin
                illegal_c = |b_open;
                ready_c   = &b_rp_done;
            end
            CMD_BST: ready_c = !g_q.ap_pend;
            default: ready_c = 1'b1;
        endcase

        ready_c     = ready_c && (g_q.busy == '0);
        grant_c     = req_valid && !illegal_c && ready_c;
        req_grant   = grant_c;
        req_stall   = req_valid && !illegal_c && !ready_c;
        req_illegal = req_valid && illegal_c;

        for (int i = 0; i < NB; i++) begin
            act_v[i]   = grant_c && (cmd == CMD_ACT) && (req_bank == 1'(i));
            wr_v[i]    = grant_c && (cmd == CMD_WR) && (req_bank == 1'(i));
            close_v[i] = b_open[i] &&
                         ((grant_c && (cmd == CMD_PRE) && (req_ap || req_bank == 1'(i))) ||
                          (ap_fire && g_q.ap_bank == 1'(i)));
        end

        g_d      = g_q;
        g_d.rrd  = step_down(g_q.rrd);
        g_d.busy = step_down(g_q.busy);
        g_d.raw  = step_down(g_q.raw);
        g_d.rd   = step_down(g_q.rd);
        g_d.ap   = step_down(g_q.ap);
        if (ap_fire) g_d.ap_pend = 1'b0;

        if (grant_c) begin
            case (cmd)
                CMD_ACT: g_d.rrd  = CW'(T_RRD - 1);
                CMD_MRS: g_d.busy = CW'(T_MRD - 1);
                CMD_REF: g_d.busy = CW'(T_RC - 1);
                CMD_BST: g_d.rd   = '0;
                CMD_RD: begin
                    g_d.rd      = CW'(BURST_LEN - 1);
                    g_d.rd_bank = req_bank;
                end
                CMD_WR: begin
                    g_d.raw = CW'(T_RAW - 1);
                    g_d.rd  = '0;
                end
                default: ;
            endcase
            if ((cmd == CMD_RD || cmd == CMD_WR) && req_ap) begin
                g_d.ap_pend = 1'b1;
                g_d.ap_bank = req_bank;
                g_d.ap      = (cmd == CMD_RD) ? CW'(T_AP_RD - 1) : CW'(T_AP_WR - 1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) g_q <= '0;
        else        g_q <= g_d;
    end

    dram_pin_drive u_pins (
        .clk   (clk),
        .rst_n (rst_n),
        .fire_i(grant_c),
        .cmd_i (cmd),
        .ap_i  (req_ap),
        .bank_i(req_bank),
        .pins_o(pins),
        .a10_o (dram_a10),
        .ba_o  (dram_ba)
    );

    assign dram_cs_n  = pins.cs_n;
    assign dram_ras_n = pins.ras_n;
    assign dram_cas_n = pins.cas_n;
    assign dram_we_n  = pins.we_n;

    p_one_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |-> $onehot({req_grant, req_stall, req_illegal}));

    p_no_reply_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |-> !(req_grant || req_stall || req_illegal));

    p_ap_holds_col_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (g_q.ap_pend && req_valid && (req_cmd == CMD_RD || req_cmd == CMD_WR)) |-> !req_grant);

    p_rd_burst_pre_bank_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (req_grant && req_cmd == CMD_PRE && !req_ap && g_q.rd != '0 && b_open[req_bank])
            |-> (req_bank == g_q.rd_bank));

    if (T_MRD >= 2) begin : g_mrd_chk
        p_mrs_lockout_r8: assert property (@(posedge clk) disable iff (!rst_n)
            (req_grant && req_cmd == CMD_MRS) |=> !req_grant);
    end

    if (T_RRD >= 2) begin : g_rrd_chk
        p_act_spacing_r6: assert property (@(posedge clk) disable iff (!rst_n)
            (req_grant && req_cmd == CMD_ACT) |=> !(req_grant && req_cmd == CMD_ACT));
    end

endmodule

// File: tb/tb_dram_cmd_gate.sv
module tb_dram_cmd_gate;

    localparam int T_RCD = 3, T_RP = 3, T_RAS = 6, T_RC = 10, T_RRD = 2;
    localparam int T_WR = 2, T_CDL = 1, T_MRD = 2, BL = 4;
    localparam logic [2:0] C_NOP = 3'd0, C_ACT = 3'd1, C_RD = 3'd2, C_WR = 3'd3;
    localparam logic [2:0] C_PRE = 3'd4, C_REF = 3'd5, C_MRS = 3'd6, C_BST = 3'd7;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [2:0] req_cmd = 3'd0;
    logic       req_bank = 1'b0;
    logic       req_ap = 1'b0;
    logic       req_grant, req_stall, req_illegal;
    logic       dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n, dram_a10, dram_ba;

    int checks = 0;
    int errors = 0;
    int cyc = 0;

    always #4 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    dram_cmd_gate #(
        .T_RCD(T_RCD), .T_RP(T_RP), .T_RAS(T_RAS), .T_RC(T_RC), .T_RRD(T_RRD),
        .T_WR(T_WR), .T_CDL(T_CDL), .T_MRD(T_MRD), .BURST_LEN(BL)
    ) dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cmd(req_cmd),
        .req_bank(req_bank), .req_ap(req_ap), .req_grant(req_grant),
        .req_stall(req_stall), .req_illegal(req_illegal), .dram_cs_n(dram_cs_n),
        .dram_ras_n(dram_ras_n), .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n),
        .dram_a10(dram_a10), .dram_ba(dram_ba)
    );

    function automatic int mx(int a, int b);
        return (a > b) ? a : b;
    endfunction

    function automatic logic [3:0] exp_pins(logic [2:0] c);
        case (c)
            C_MRS:   return 4'b0000;
            C_REF:   return 4'b0001;
            C_ACT:   return 4'b0011;
            C_RD:    return 4'b0101;
            C_WR:    return 4'b0100;
            C_PRE:   return 4'b0010;
            C_BST:   return 4'b0110;
            default: return 4'b0111;
        endcase
    endfunction

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic issue(input logic [2:0] c, input logic b, input logic ap, output int g);
        int waits = 0;
        logic ea10, eba;
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_ap = ap;
        #1;
        while (!req_grant && waits < 60) begin
            check((req_stall && !req_illegal), "R11 stall reply", {req_grant, req_stall, req_illegal}, 2);
            @(negedge clk);
            #1;
            waits++;
        end
        check(req_grant && !req_stall && !req_illegal, "R11 grant reply", {req_grant, req_stall, req_illegal}, 4);
        g = cyc;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == exp_pins(c), "R1 pins",
              {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, exp_pins(c));
        ea10 = (c == C_RD || c == C_WR || c == C_PRE) ? ap : 1'b0;
        eba  = (c == C_ACT || c == C_RD || c == C_WR || (c == C_PRE && !ap)) ? b : 1'b0;
        check({dram_a10, dram_ba} == {ea10, eba}, "R2 a10/ba", {dram_a10, dram_ba}, {ea10, eba});
    endtask

    task automatic expect_illegal(input logic [2:0] c, input logic b, input logic ap, input string tag);
        @(negedge clk);
        req_valid = 1'b1; req_cmd = c; req_bank = b; req_ap = ap;
        #1;
        check(req_illegal && !req_grant && !req_stall, tag, {req_grant, req_stall, req_illegal}, 1);
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        check({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == 4'b0111, tag,
              {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, 7);
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #160000;
        check(1'b0, "R11 watchdog", cyc, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int a, b, g1, g2, g3, g4, r, w, w2, p, x, q, y, z, s, t;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == 4'b0111, "R1 reset pins",
              {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, 7);
        check(!(req_grant || req_stall || req_illegal), "R11 no request", {req_grant, req_stall, req_illegal}, 0);

        // R8: mode-set and refresh lockouts
        issue(C_MRS, 1'b0, 1'b0, g1);
        issue(C_REF, 1'b0, 1'b0, g2);
        check(g2 - g1 == T_MRD, "R8 MRS to REF", g2 - g1, T_MRD);
        issue(C_ACT, 1'b0, 1'b0, g3);
        check(g3 - g2 == T_RC, "R8 REF to ACT", g3 - g2, T_RC);
        issue(C_PRE, 1'b0, 1'b1, g4);
        check(g4 - g3 == T_RAS, "R5 ACT to PRE-all", g4 - g3, T_RAS);
        idle(10);

        // R4 R5 R6: activation spacing
        issue(C_ACT, 1'b0, 1'b0, a);
        issue(C_ACT, 1'b1, 1'b0, b);
        check(b - a == T_RRD, "R6 ACT to ACT other bank", b - a, T_RRD);
        issue(C_RD, 1'b0, 1'b0, r);
        check(r - a == T_RCD, "R4 ACT to RD", r - a, T_RCD);
        issue(C_PRE, 1'b0, 1'b0, p);
        check(p - a == T_RAS, "R5 ACT to PRE", p - a, T_RAS);
        issue(C_ACT, 1'b0, 1'b0, x);
        check(x == mx(p + T_RP, a + T_RC), "R5 re-ACT", x, mx(p + T_RP, a + T_RC));

        // R3: illegal requests with both banks open
        expect_illegal(C_ACT, 1'b0, 1'b0, "R3 ACT open bank");
        expect_illegal(C_REF, 1'b0, 1'b0, "R3 REF with open bank");
        expect_illegal(C_MRS, 1'b0, 1'b0, "R3 MRS with open bank");
        issue(C_PRE, 1'b0, 1'b1, g1);
        expect_illegal(C_RD, 1'b0, 1'b0, "R3 RD idle bank");
        expect_illegal(C_WR, 1'b1, 1'b0, "R3 WR idle bank");
        idle(12);

        // R7: write recovery and read after write
        issue(C_ACT, 1'b0, 1'b0, a);
        issue(C_WR, 1'b0, 1'b0, w);
        check(w - a == T_RCD, "R4 ACT to WR", w - a, T_RCD);
        issue(C_RD, 1'b0, 1'b0, r);
        check(r - w == BL + T_CDL - 1, "R7 WR to RD", r - w, BL + T_CDL - 1);
        issue(C_WR, 1'b0, 1'b0, w2);
        check(w2 - r == 1, "R7 WR not held", w2 - r, 1);
        issue(C_PRE, 1'b0, 1'b0, p);
        check(p == mx(w2 + BL + T_WR - 1, a + T_RAS), "R7 WR to PRE", p, mx(w2 + BL + T_WR - 1, a + T_RAS));
        idle(12);

        // R9: auto-precharge bursts
        issue(C_ACT, 1'b0, 1'b0, a);
        issue(C_ACT, 1'b1, 1'b0, b);
        issue(C_RD, 1'b0, 1'b1, r);
        issue(C_RD, 1'b1, 1'b0, q);
        check(q - r == BL + 1, "R9 RD-AP blocks column", q - r, BL + 1);
        issue(C_ACT, 1'b0, 1'b0, y);
        check(y == mx(r + BL + T_RP, a + T_RC), "R9 re-ACT after RD-AP", y, mx(r + BL + T_RP, a + T_RC));
        issue(C_WR, 1'b1, 1'b1, w);
        issue(C_ACT, 1'b1, 1'b0, z);
        check(z - w == BL + T_WR - 1 + T_RP, "R9 re-ACT after WR-AP", z - w, BL + T_WR - 1 + T_RP);
        issue(C_PRE, 1'b0, 1'b1, g1);
        idle(12);

        // R10: precharge during a read burst, burst stop
        issue(C_ACT, 1'b0, 1'b0, a);
        issue(C_ACT, 1'b1, 1'b0, b);
        idle(8);
        issue(C_RD, 1'b0, 1'b0, r);
        issue(C_PRE, 1'b1, 1'b0, p);
        check(p - r == BL, "R10 PRE other bank waits burst", p - r, BL);
        issue(C_ACT, 1'b1, 1'b0, x);
        idle(8);
        issue(C_RD, 1'b0, 1'b0, r);
        issue(C_BST, 1'b0, 1'b0, s);
        check(s - r == 1, "R10 BST granted", s - r, 1);
        issue(C_PRE, 1'b1, 1'b0, q);
        check(q - s == 1, "R10 PRE after BST", q - s, 1);
        issue(C_RD, 1'b0, 1'b0, r);
        issue(C_PRE, 1'b0, 1'b0, t);
        check(t - r == 1, "R10 PRE same bank", t - r, 1);
        idle(2);
        #1;
        check({dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n} == 4'b0111, "R1 idle pins",
              {dram_cs_n, dram_ras_n, dram_cas_n, dram_we_n}, 7);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule